// File: doc/BRIEF.md
# Triggered Single-Channel DMA Request Sequencer

This block is one DMA channel that is driven by single-cycle trigger pulses from a peripheral. Software first arms it with a total element count, an element count per burst and a destination base address. Each trigger that the channel accepts starts one burst. A burst fetches the channel's control information over a fixed number of cycles. It then copies elements one at a time from a valid/ready read port to a valid/ready write port, and closes with a one-cycle write-back of the control word. A bus-grant input stands in for arbitration and can stall any element move.

A burst copies the per-burst count of elements, or fewer when fewer remain. While a burst is running the channel can remember one extra trigger. Any trigger beyond that is lost and counted in a saturating counter, so that overdriving the trigger is visible at the ports. After the last element of the whole transfer, the channel raises a single done pulse, disables itself and ignores triggers until it is armed again.

States and transitions: `ST_IDLE` goes to `ST_LOAD` on a trigger or a held trigger while enabled. `ST_LOAD` goes to `ST_READ` when its cycle counter expires. `ST_READ` goes to `ST_WRITE` on a granted read handshake. `ST_WRITE` goes back to `ST_READ` on a granted write while the burst has elements left, and to `ST_WBACK` after the burst's last element. `ST_WBACK` goes to `ST_IDLE` when the transfer is finished or nothing is held, and to `ST_LOAD` when a held trigger is waiting.

Top module: `dma_req_seq`

## Requirements
- R1: After reset `active`, `src_ready`, `snk_valid` and `done_irq` are 0 and `drop_count` is 0.
- R2: A pulse on `arm` while no burst is running latches `cfg_total`, `cfg_burst` (0 is taken as 1) and `cfg_dst_base`. It sets `active` to 1 if `cfg_total` is nonzero and leaves it 0 otherwise.
- R3: A trigger seen by an active, idle channel enters `ST_LOAD` on the next edge. `src_ready` then stays 0 for exactly LOAD_CYC (default 6) cycles before it can first rise.
- R4: An element is read when `src_valid`, `src_ready` and `bus_grant` are all high. `src_ready` is high only in `ST_READ` while `bus_grant` is high. The element is written when `snk_valid`, `snk_ready` and `bus_grant` are all high. Each element takes at least 2 cycles, and a low `bus_grant` stalls it.
- R5: The n-th write of a transfer (counting from 0) goes to `cfg_dst_base + n*ELEM_BYTES` (default 4). Elements are written in the order they were read.
- R6: A burst moves min(burst count, remaining count) elements, so a short last burst moves only what remains. It then spends one cycle in `ST_WBACK`.
- R7: During a burst one further trigger is held and later served as a burst of its own. Triggers that arrive while the slot is already full are dropped.
- R8: Each dropped trigger adds 1 to `drop_count`, which saturates at 2^DROP_W-1 (default 15). `drop_clr` sets it to 0 and takes priority over an increment.
- R9: `done_irq` is a one-cycle pulse in the write-back of the burst that moves the final element. It is never raised after an intermediate burst.
- R10: After completion `active` is 0, any held trigger is discarded, and triggers start no burst and do not change `drop_count` until the channel is armed again.
- R11: A burst count of 1 works, giving one element per trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Load configuration and enable channel |
| cfg_total | input | CNT_W | Total elements of the transfer |
| cfg_burst | input | BURST_W | Elements per accepted trigger |
| cfg_dst_base | input | ADDR_W | First destination byte address |
| trig | input | 1 | Peripheral request pulse |
| drop_clr | input | 1 | Clear dropped-trigger count |
| bus_grant | input | 1 | Arbitration grant; low stalls moves |
| src_valid | input | 1 | Source element available |
| src_data | input | DATA_W | Source element (fixed register) |
| src_ready | output | 1 | Source element taken this cycle |
| snk_valid | output | 1 | Write request to memory |
| snk_addr | output | ADDR_W | Write byte address |
| snk_data | output | DATA_W | Write data |
| snk_ready | input | 1 | Memory accepts the write |
| active | output | 1 | Channel enabled |
| done_irq | output | 1 | Whole-transfer completion pulse |
| drop_count | output | DROP_W | Saturating lost-trigger count |

## Verification
A wrong remaining or per-burst count shows up as the wrong number of sink writes at the end of a transfer, or as `done_irq` appearing early or never. It becomes visible within one burst of the fault. A faulty address register shows up at the first write that follows, as an address off its base-plus-stride line. A faulty load counter moves the first rise of `src_ready` away from its fixed distance after the trigger. A broken pending slot changes how many bursts run and what `drop_count` reads within a few cycles of a burst of triggers.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_READ,
        ST_WRITE,
        ST_WBACK
    } seq_state_t;
endpackage

// File: rtl/dma_trig_slot.sv
module dma_trig_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic en,
    input  logic busy,
    input  logic take,
    input  logic flush,
    output logic pend,
    output logic drop_inc
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (flush) begin
            pend <= 1'b0;
        end else if (trig && en && busy) begin
            pend <= 1'b1;
        end else if (take) begin
            pend <= 1'b0;
        end
    end

    assign drop_inc = trig && en && busy && pend && !take && !flush;

    // R7: a held trigger is kept until it is served or flushed
    assert_slot_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !take && !flush) |=> pend);
endmodule

// File: rtl/dma_drop_ctr.sv
module dma_drop_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && cnt != MAXV) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_drop_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> cnt == MAXV);
    assert_drop_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
    import dma_seq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 12,
    parameter int BURST_W    = 5,
    parameter int ELEM_BYTES = 4,
    parameter int LOAD_CYC   = 6,
    parameter int DROP_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [CNT_W-1:0]  cfg_total,
    input  logic [BURST_W-1:0] cfg_burst,
    input  logic [ADDR_W-1:0] cfg_dst_base,
    input  logic              trig,
    input  logic              drop_clr,
    input  logic              bus_grant,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic              snk_valid,
    output logic [ADDR_W-1:0] snk_addr,
    output logic [DATA_W-1:0] snk_data,
    input  logic              snk_ready,
    output logic              active,
    output logic              done_irq,
    output logic [DROP_W-1:0] drop_count
);
    localparam int LCNT_W = $clog2(LOAD_CYC + 1);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(ELEM_BYTES);

    seq_state_t state, nxt;
    logic               en;
    logic [CNT_W-1:0]   rem;
    logic [BURST_W-1:0] blen, beat;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  data_q;
    logic [LCNT_W-1:0]  ldcnt;
    logic pend, drop_inc, take, arm_ok, finish, rd_hs, wr_hs, busy;

    assign arm_ok = arm && (state == ST_IDLE);
    assign finish = (state == ST_WBACK) && (rem == '0);
    assign rd_hs  = (state == ST_READ) && src_valid && bus_grant;
    assign wr_hs  = (state == ST_WRITE) && snk_ready && bus_grant;
    assign busy   = (state != ST_IDLE) || pend;

    dma_trig_slot u_slot (
        .clk(clk), .rst_n(rst_n), .trig(trig), .en(en), .busy(busy),
        .take(take), .flush(arm_ok || finish), .pend(pend), .drop_inc(drop_inc)
    );

    dma_drop_ctr #(.W(DROP_W)) u_drop (
        .clk(clk), .rst_n(rst_n), .inc(drop_inc), .clr(drop_clr), .cnt(drop_count)
    );

    // next-state logic
    always_comb begin
        nxt  = state;
        take = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (en && (trig || pend)) nxt = ST_LOAD;
                take = en && pend;
            end
            ST_LOAD:  if (ldcnt == '0) nxt = ST_READ;
            ST_READ:  if (rd_hs) nxt = ST_WRITE;
            ST_WRITE: if (wr_hs) nxt = (beat == BURST_W'(1)) ? ST_WBACK : ST_READ;
            ST_WBACK: begin
                if (rem == '0) begin
                    nxt = ST_IDLE;
                end else if (pend) begin
                    nxt  = ST_LOAD;
                    take = 1'b1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // channel datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; rem <= '0; blen <= '0; beat <= '0;
            addr <= '0; data_q <= '0; ldcnt <= '0;
        end else begin
            if (arm_ok) begin
                rem  <= cfg_total;
                blen <= (cfg_burst == '0) ? BURST_W'(1) : cfg_burst;
                addr <= cfg_dst_base;
                en   <= (cfg_total != '0);
            end
            if (state != ST_LOAD && nxt == ST_LOAD) begin
                ldcnt <= LCNT_W'(LOAD_CYC - 1);
                beat  <= (rem < {{(CNT_W-BURST_W){1'b0}}, blen}) ? rem[BURST_W-1:0] : blen;
            end else if (state == ST_LOAD && ldcnt != '0) begin
                ldcnt <= ldcnt - 1'b1;
            end
            if (rd_hs) data_q <= src_data;
            if (wr_hs) begin
                addr <= addr + STRIDE;
                rem  <= rem - 1'b1;
                beat <= beat - 1'b1;
            end
            if (finish) en <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        src_ready = (state == ST_READ) && bus_grant;
        snk_valid = (state == ST_WRITE);
        snk_addr  = addr;
        snk_data  = data_q;
        done_irq  = finish;
        active    = en;
    end

    assert_start_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && en && trig) |=> state == ST_LOAD);
    assert_grant_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && !bus_grant) |=> state == ST_WRITE);
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hs |=> snk_addr == $past(snk_addr) + STRIDE);
    assert_move_has_work_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ || state == ST_WRITE) |-> (rem != '0 && beat != '0));
    assert_queue_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WBACK && rem != '0 && pend) |=> state == ST_LOAD);
    assert_done_disables_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !active);
    assert_idle_stays_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !en && !arm) |=> (state == ST_IDLE && !en));
endmodule

// File: tb/test_dma_req_seq.sv
module test_dma_req_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0, trig = 1'b0, drop_clr = 1'b0;
    logic [11:0] cfg_total = '0;
    logic [4:0]  cfg_burst = '0;
    logic [15:0] cfg_dst_base = '0;
    logic        bus_grant = 1'b1, src_valid = 1'b1, snk_ready = 1'b1;
    logic [31:0] src_data = 32'h1000;
    logic        src_ready, snk_valid, active, done_irq;
    logic [15:0] snk_addr;
    logic [31:0] snk_data;
    logic [3:0]  drop_count;

    always #10 clk = ~clk;

    dma_req_seq i_dma_req_seq (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_total(cfg_total),
        .cfg_burst(cfg_burst), .cfg_dst_base(cfg_dst_base), .trig(trig),
        .drop_clr(drop_clr), .bus_grant(bus_grant), .src_valid(src_valid),
        .src_data(src_data), .src_ready(src_ready), .snk_valid(snk_valid),
        .snk_addr(snk_addr), .snk_data(snk_data), .snk_ready(snk_ready),
        .active(active), .done_irq(done_irq), .drop_count(drop_count)
    );

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, done_cnt = 0, cyc = 0;
    bit gtog = 1'b0, rd_pend = 1'b0, finished = 1'b0;
    logic [15:0] cur_base = '0;
    logic [31:0] exp_data = 32'h1000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // source/sink model and monitor, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rd_pend) src_data = src_data + 1;
            rd_pend = 1'b0;
            cyc++;
            bus_grant = gtog ? cyc[0] : 1'b1;
            #1;
            if (src_ready && src_valid) rd_pend = 1'b1;
            if (snk_valid && snk_ready && bus_grant) begin
                chk("R5 addr", 32'(snk_addr), 32'(cur_base + 16'(wr_cnt * 4)));
                chk("R5 data", snk_data, exp_data);
                exp_data = exp_data + 1;
                wr_cnt++;
            end
            if (done_irq) done_cnt++;
        end
    end

    task automatic do_arm(input logic [11:0] t, input logic [4:0] b, input logic [15:0] base);
        @(negedge clk);
        cfg_total = t; cfg_burst = b; cfg_dst_base = base; arm = 1'b1;
        cur_base = base; wr_cnt = 0; done_cnt = 0;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic trig_run(input int n);
        @(negedge clk);
        trig = 1'b1;
        repeat (n) @(negedge clk);
        trig = 1'b0;
    endtask

    typedef struct packed {
        logic [11:0] total;
        logic [4:0]  burst;
        logic [15:0] base;
        logic [3:0]  ntrig;
        logic        tog;
        logic [7:0]  exp_wr;
        logic [1:0]  exp_done;
        logic        exp_act;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{12'd4,  5'd1, 16'h0100, 4'd4, 1'b0, 8'd4, 2'd1, 1'b0},  // R11 single element bursts
        '{12'd8,  5'd2, 16'h0200, 4'd4, 1'b1, 8'd8, 2'd1, 1'b0},  // R4 stalled grant
        '{12'd5,  5'd4, 16'h0040, 4'd2, 1'b0, 8'd5, 2'd1, 1'b0},  // R6 short final burst
        '{12'd12, 5'd4, 16'h0300, 4'd2, 1'b1, 8'd8, 2'd0, 1'b1},  // R9 no done mid-transfer
        '{12'd6,  5'd3, 16'h0010, 4'd3, 1'b0, 8'd6, 2'd1, 1'b0}   // R9 done at end
    };

    initial begin
        repeat (3) @(negedge clk);
        #3;
        // R1 reset state
        chk("R1 active", 32'(active), 32'd0);
        chk("R1 src_ready", 32'(src_ready), 32'd0);
        chk("R1 snk_valid", 32'(snk_valid), 32'd0);
        chk("R1 done_irq", 32'(done_irq), 32'd0);
        chk("R1 drop_count", 32'(drop_count), 32'd0);
        rst_n = 1'b1;

        // R2 zero total leaves channel off
        do_arm(12'd0, 5'd2, 16'h0000);
        #3 chk("R2 zero total", 32'(active), 32'd0);

        foreach (VECS[i]) begin
            gtog = VECS[i].tog;
            do_arm(VECS[i].total, VECS[i].burst, VECS[i].base);
            #3 chk("R2 armed", 32'(active), 32'd1);
            for (int k = 0; k < int'(VECS[i].ntrig); k++) begin
                trig_run(1);
                repeat (40) @(negedge clk);
            end
            #3;
            chk("R6 write count", 32'(wr_cnt), 32'(VECS[i].exp_wr));
            chk("R9 done count", 32'(done_cnt), 32'(VECS[i].exp_done));
            chk("R10 active after", 32'(active), 32'(VECS[i].exp_act));
        end
        gtog = 1'b0;

        // R10: disabled channel ignores triggers (last vector completed)
        wr_cnt = 0;
        trig_run(3);
        repeat (20) @(negedge clk);
        #3;
        chk("R10 no writes when off", 32'(wr_cnt), 32'd0);
        chk("R10 drop unchanged", 32'(drop_count), 32'd0);

        // R3: load phase length
        do_arm(12'd2, 5'd1, 16'h0500);
        trig_run(1);
        begin
            int zeros = 0;
            for (int k = 0; k < 20; k++) begin
                #3;
                if (src_ready) break;
                zeros++;
                @(negedge clk);
            end
            chk("R3 load cycles", 32'(zeros), 32'd6);
        end
        repeat (30) @(negedge clk);

        // R7: one held, extras dropped
        do_arm(12'd8, 5'd4, 16'h0600);
        trig_run(4);
        repeat (60) @(negedge clk);
        #3;
        chk("R7 drop count", 32'(drop_count), 32'd2);
        chk("R7 two bursts", 32'(wr_cnt), 32'd8);
        chk("R9 single done", 32'(done_cnt), 32'd1);

        // R8: saturation then clear
        do_arm(12'd60, 5'd16, 16'h0800);
        trig_run(30);
        #3 chk("R8 saturate", 32'(drop_count), 32'd15);
        @(negedge clk); drop_clr = 1'b1;
        @(negedge clk); drop_clr = 1'b0;
        #3 chk("R8 clear", 32'(drop_count), 32'd0);
        repeat (120) @(negedge clk);
        #3 chk("R7 held burst served", 32'(wr_cnt), 32'd32);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule